// File: doc/BRIEF.md
# Reloading Timer Bank with Free-Running Wide Counter

This block holds three down-counting interval timers and one wide up-counter behind a plain 32-bit register port. The first two interval timers are 16 bits wide and the third is 32 bits wide. Each interval timer counts on one of two tick strobes: a fast strobe or a slow strobe. When it passes zero it either reloads from its load register or wraps to all ones, and it raises a sticky interrupt that software drops by writing any value to the timer's clear address. The 40-bit counter counts up on its own tick strobe whenever it is enabled. It has no interrupt, and software reads it as a low word and a high part.

The tick strobes are one-cycle clock enables that come from outside the block. Interrupt lines go to an external interrupt controller. The register port is a simple one: a write is a single cycle with `bus_wr` high, and read data is a combinational function of `bus_addr`. It has no valid/ready handshake and it never stalls. Address bits [1:0] are ignored.

Top module: `timer_bank`

## Requirements
- R1: After reset every register reads 0, every counter is stopped and all interrupt lines are low.
- R2: A write to a timer's load register (offset 0x00 from its base) stores the value and copies it into the count in the same edge, whether or not the timer is enabled. The new count is visible from the following cycle, and a load write takes priority over a tick in that cycle.
- R3: An enabled timer decrements by one on each cycle in which its selected tick is high. The count does not change without that tick, and it does not change while the timer is disabled.
- R4: The control register (offset 0x08) holds enable in bit 7, periodic mode in bit 6 and tick select in bit 3 (1 = fast tick, 0 = slow tick). These bits read back at the same positions, and all other bits read 0. A control write takes effect from the next cycle.
- R5: In periodic mode a tick at count 0 reloads the load value, so the interrupt period is load+1 ticks.
- R6: In free-running mode a tick at count 0 wraps the count to all ones of the timer's width (0xFFFF or 0xFFFFFFFF).
- R7: A tick at count 0 sets that timer's interrupt line, which stays high until a write of any data to the timer's clear address (offset 0x0C).
- R8: If a clear write and an underflow happen in the same cycle, the interrupt stays set.
- R9: Timers at bases 0x00 and 0x20 are 16 bits wide: the upper write bits are dropped, and their load and value registers read zero above bit 15. The timer at base 0x80 is 32 bits wide.
- R10: The wide counter counts up by one on each wide tick while it is enabled. Bit 8 written to offset 0x64 sets or clears the enable. A read of 0x60 returns count bits [31:0]. A read of 0x64 returns count bits [39:32] in bits [7:0] and the enable in bit 8. Wide ticks never touch any interrupt line.
- R11: The value register (offset 0x04) reads the live count. Writes to value registers and to 0x60 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_fast | input | 1 | Fast count enable strobe |
| tick_slow | input | 1 | Slow count enable strobe |
| tick_wide | input | 1 | Count enable strobe for the wide counter |
| irq | output | 3 | Sticky underflow interrupts, bit i for interval timer i |

## Verification
Every state change in this block lands on the edge that samples the write or tick, so count, control and interrupt changes are due one edge after the stimulus. Read data has no latency of its own, because it is a combinational function of the address. The bench drives each stimulus on a falling edge and updates its model at the following rising edge. It compares `irq` one nanosecond after that edge, then sets `bus_addr` with no strobes active and compares `bus_rdata` before the next rising edge. Nothing is compared inside the cycle in which it changes.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;

  // control bit positions
  localparam int CTL_EN   = 7;
  localparam int CTL_PER  = 6;
  localparam int CTL_FAST = 3;
  localparam int WIDE_EN  = 8;

  // register selects inside one timer window (addr[3:2])
  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_CLEAR = 2'd3
  } reg_sel_e;

  localparam logic [3:0] WIDE_WINDOW = 4'h6;

  function automatic logic [3:0] timer_window(input int idx);
    case (idx)
      0:       return 4'h0;
      1:       return 4'h2;
      default: return 4'h8;
    endcase
  endfunction
endpackage

// File: rtl/reload_timer.sv
module reload_timer
  import timer_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic [DATA_W-1:0] rd_word,
  output logic              irq
);
  logic [W-1:0] load_q, cnt_q;
  logic         en_q, per_q, fast_q, irq_q;
  logic         load_wr, ctrl_wr, clr_wr, tick, uf;

  assign load_wr = wr_en && (reg_sel == SEL_LOAD);
  assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);
  assign clr_wr  = wr_en && (reg_sel == SEL_CLEAR);
  assign tick    = fast_q ? tick_fast : tick_slow;
  assign uf      = en_q && tick && (cnt_q == '0) && !load_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      fast_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (load_wr) begin
        load_q <= wdata[W-1:0];
        cnt_q  <= wdata[W-1:0];
      end else if (en_q && tick) begin
        if (cnt_q == '0) cnt_q <= per_q ? load_q : '1;
        else             cnt_q <= cnt_q - 1'b1;
      end
      if (ctrl_wr) begin
        en_q   <= wdata[CTL_EN];
        per_q  <= wdata[CTL_PER];
        fast_q <= wdata[CTL_FAST];
      end
      if (uf)          irq_q <= 1'b1;
      else if (clr_wr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    case (reg_sel)
      SEL_LOAD:  rd_word = DATA_W'(load_q);
      SEL_VALUE: rd_word = DATA_W'(cnt_q);
      SEL_CTRL: begin
        rd_word[CTL_EN]   = en_q;
        rd_word[CTL_PER]  = per_q;
        rd_word[CTL_FAST] = fast_q;
      end
      default:   rd_word = '0;
    endcase
  end

  assign irq = irq_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> cnt_q == $past(wdata[W-1:0]));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !load_wr) |=> $stable(cnt_q));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && per_q) |=> cnt_q == $past(load_q));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !per_q) |=> cnt_q == {W{1'b1}});
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_wr) |=> irq_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !uf) |=> !irq_q);
  p_uf_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> irq_q);
endmodule

// File: rtl/wide_counter.sv
module wide_counter
  import timer_bank_pkg::*;
#(
  parameter int FREE_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic [DATA_W-1:0] rd_word
);
  logic [FREE_W-1:0] cnt_q;
  logic              en_q;
  logic              en_wr;

  assign en_wr = wr_en && (reg_sel == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (en_q && tick) cnt_q <= cnt_q + 1'b1;
      if (en_wr)        en_q  <= wdata[WIDE_EN];
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    rd_word = cnt_q[DATA_W-1:0];
      2'd1: begin
        rd_word = DATA_W'(cnt_q >> DATA_W);
        rd_word[WIDE_EN] = en_q;
      end
      default: rd_word = '0;
    endcase
  end

  p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(cnt_q));
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              tick_wide,
  output logic [2:0]        irq
);
  localparam int NUM_TMR = 3;

  logic [3:0]        window;
  logic [1:0]        sel;
  logic [DATA_W-1:0] tmr_rd [NUM_TMR];
  logic [NUM_TMR-1:0] tmr_hit;
  logic [DATA_W-1:0] wide_rd;
  logic              wide_hit;

  assign window   = bus_addr[ADDR_W-1:4];
  assign sel      = bus_addr[3:2];
  assign wide_hit = (window == WIDE_WINDOW);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int TW = (i == NUM_TMR - 1) ? WIDE_W : NARROW_W;
    assign tmr_hit[i] = (window == timer_window(i));
    reload_timer #(.W(TW)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr && tmr_hit[i]),
      .reg_sel   (sel),
      .wdata     (bus_wdata),
      .tick_fast (tick_fast),
      .tick_slow (tick_slow),
      .rd_word   (tmr_rd[i]),
      .irq       (irq[i])
    );
  end

  wide_counter #(.FREE_W(FREE_W)) u_wide (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr && wide_hit),
    .reg_sel (sel),
    .wdata   (bus_wdata),
    .tick    (tick_wide),
    .rd_word (wide_rd)
  );

  always_comb begin
    bus_rdata = wide_hit ? wide_rd : '0;
    for (int i = 0; i < NUM_TMR; i++)
      if (tmr_hit[i]) bus_rdata = bus_rdata | tmr_rd[i];
  end
endmodule

// File: tb/timer_bank_bench.sv
module timer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_fast = 1'b0, tick_slow = 1'b0, tick_wide = 1'b0;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_load [3];
  logic [31:0] m_cnt  [3];
  bit          m_en [3], m_per [3], m_fast [3], m_irq [3];
  logic [39:0] w_cnt;
  bit          w_en;

  always #2.5 clk = ~clk;

  timer_bank u_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .tick_wide(tick_wide), .irq(irq)
  );

  function automatic logic [3:0] win_of(int i);
    return (i == 0) ? 4'h0 : (i == 1) ? 4'h2 : 4'h8;
  endfunction

  function automatic logic [31:0] mask_of(int i);
    return (i == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 3; i++)
      if (a[7:4] == win_of(i))
        case (a[3:2])
          2'd0: r = m_load[i];
          2'd1: r = m_cnt[i];
          2'd2: r = {24'd0, m_en[i], m_per[i], 2'b00, m_fast[i], 3'b000};
          default: r = '0;
        endcase
    if (a[7:4] == 4'h6)
      case (a[3:2])
        2'd0: r = w_cnt[31:0];
        2'd1: r = {23'd0, w_en, w_cnt[39:32]};
        default: r = '0;
      endcase
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_load[i] = '0; m_cnt[i] = '0; m_en[i] = 0; m_per[i] = 0;
      m_fast[i] = 0; m_irq[i] = 0;
    end
    w_cnt = '0; w_en = 0;
  endtask

  task automatic model_step(bit we, logic [7:0] a, logic [31:0] d,
                            bit tf, bit ts, bit tw);
    for (int i = 0; i < 3; i++) begin
      bit hit, lw, tk, uf;
      hit = we && (a[7:4] == win_of(i));
      lw  = hit && (a[3:2] == 2'd0);
      tk  = m_fast[i] ? tf : ts;
      uf  = m_en[i] && tk && (m_cnt[i] == 0) && !lw;
      if (lw) begin
        m_load[i] = d & mask_of(i);
        m_cnt[i]  = d & mask_of(i);
      end else if (m_en[i] && tk) begin
        if (m_cnt[i] == 0) m_cnt[i] = m_per[i] ? m_load[i] : mask_of(i);
        else               m_cnt[i] = m_cnt[i] - 1;
      end
      if (hit && a[3:2] == 2'd2) begin
        m_en[i] = d[7]; m_per[i] = d[6]; m_fast[i] = d[3];
      end
      if (uf) m_irq[i] = 1;
      else if (hit && a[3:2] == 2'd3) m_irq[i] = 0;
    end
    if (w_en && tw) w_cnt = w_cnt + 1;
    if (we && a == 8'h64) w_en = d[8];
  endtask

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit we, logic [7:0] a, logic [31:0] d,
                     bit tf, bit ts, bit tw);
    @(negedge clk);
    bus_wr = we; bus_addr = a; bus_wdata = d;
    tick_fast = tf; tick_slow = ts; tick_wide = tw;
    @(posedge clk);
    model_step(we, a, d, tf, ts, tw);
    #1;
    bus_wr = 0; tick_fast = 0; tick_slow = 0; tick_wide = 0;
    check("irq R7", {37'd0, irq}, {37'd0, m_irq[2], m_irq[1], m_irq[0]});
  endtask

  task automatic rd(string tag, logic [7:0] a);
    bus_addr = a;
    #0.5;
    check(tag, {8'd0, bus_rdata}, {8'd0, model_read(a)});
  endtask

  task automatic ticks(bit tf, bit ts, int n);
    for (int k = 0; k < n; k++) cyc(0, 8'h10, 0, tf, ts, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [7:0] addrs [14];
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h20, 8'h24, 8'h28, 8'h2C,
              8'h80, 8'h84, 8'h88, 8'h8C, 8'h60, 8'h64};
    seed = $urandom(32'd2024);
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 14; k++) rd("R1 reset read", addrs[k]);
    check("R1 irq", {37'd0, irq}, 40'd0);

    // R2 load, R4 control
    cyc(1, 8'h00, 32'd5, 0, 0, 0);
    rd("R2 value after load", 8'h04);
    rd("R2 load readback", 8'h00);
    cyc(1, 8'h08, 32'hFFFF_FFC8, 0, 0, 0);
    rd("R4 ctrl readback", 8'h08);
    ticks(0, 1, 3);
    rd("R4 slow tick ignored", 8'h04);
    // R3 / R5 / R7 periodic count
    ticks(1, 0, 2);
    rd("R3 decrement", 8'h04);
    ticks(1, 0, 3);
    rd("R3 reached zero", 8'h04);
    check("R7 no irq before underflow", {39'd0, irq[0]}, 40'd0);
    ticks(1, 0, 1);
    rd("R5 reload after load+1 ticks", 8'h04);
    check("R7 irq set", {39'd0, irq[0]}, 40'd1);
    cyc(0, 8'h10, 0, 0, 0, 0);
    check("R7 irq sticky", {39'd0, irq[0]}, 40'd1);
    cyc(1, 8'h0C, 32'h1234, 0, 0, 0);
    check("R7 clear any data", {39'd0, irq[0]}, 40'd0);
    // R8 clear with underflow
    ticks(1, 0, 5);
    cyc(1, 8'h0C, 0, 1, 0, 0);
    check("R8 underflow beats clear", {39'd0, irq[0]}, 40'd1);
    cyc(1, 8'h0C, 0, 0, 0, 0);

    // R6 free-running wrap on 16-bit timer
    cyc(1, 8'h28, 32'h80, 0, 0, 0);
    cyc(1, 8'h20, 32'd1, 0, 0, 0);
    ticks(0, 1, 2);
    rd("R6 wrap 16-bit", 8'h24);
    check("R6 irq on wrap", {39'd0, irq[1]}, 40'd1);
    // R9 widths
    cyc(1, 8'h20, 32'hABCD_1234, 0, 0, 0);
    rd("R9 narrow load", 8'h20);
    rd("R9 narrow value", 8'h24);
    cyc(1, 8'h80, 32'hABCD_1234, 0, 0, 0);
    rd("R9 wide load", 8'h80);
    // R2 load while enabled, R11 value write ignored
    cyc(1, 8'h88, 32'h88, 0, 0, 0);
    ticks(1, 0, 2);
    rd("R3 32-bit decrement", 8'h84);
    cyc(1, 8'h84, 32'h5555, 1, 0, 0);
    rd("R11 value write ignored", 8'h84);
    cyc(1, 8'h80, 32'h10, 1, 0, 0);
    rd("R2 load while enabled", 8'h84);
    // R6 wrap 32-bit
    cyc(1, 8'h88, 32'h08, 0, 0, 0);
    cyc(1, 8'h80, 32'h0, 0, 0, 0);
    cyc(1, 8'h88, 32'h88, 0, 0, 0);
    ticks(1, 0, 1);
    rd("R6 wrap 32-bit", 8'h84);
    // R3 disabled timer holds
    cyc(1, 8'h08, 32'h0, 0, 0, 0);
    ticks(1, 1, 4);
    rd("R3 disabled holds", 8'h04);

    // R10 wide counter
    for (int i = 0; i < 3; i++) cyc(1, {win_of(i), 4'hC}, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(1, {win_of(i), 4'h8}, 0, 0, 0, 0);
    cyc(0, 8'h10, 0, 0, 0, 1);
    rd("R10 disabled no count", 8'h60);
    cyc(1, 8'h64, 32'h100, 0, 0, 0);
    rd("R10 enable readback", 8'h64);
    for (int k = 0; k < 3; k++) cyc(0, 8'h10, 0, 0, 0, 1);
    rd("R10 low word", 8'h60);
    rd("R10 high part", 8'h64);
    check("R10 no irq", {37'd0, irq}, 40'd0);
    cyc(1, 8'h60, 32'hFFFF, 0, 0, 1);
    rd("R11 low write ignored", 8'h60);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit we;
      logic [7:0] a;
      logic [31:0] d;
      we = ($urandom % 4) == 0;
      a  = addrs[$urandom % 14];
      d  = $urandom;
      if (a[3:2] == 2'd0 && ($urandom % 4) != 0) d = $urandom % 8;
      cyc(we, a, d, ($urandom % 2) == 1, ($urandom % 3) == 0,
          ($urandom % 2) == 1);
      rd("R5 R6 R3 random read", addrs[$urandom % 14]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule